// File: doc/BRIEF.md
# Per-Hart Timer and Software Interrupt Unit

This unit gives a small multi-hart system one shared 64-bit time counter. Each hart has its own 64-bit compare value and its own software-interrupt flag. From these, each hart gets two separate interrupt outputs. The timer interrupt is a level that stays high while the counter is at or past that hart's compare value. The software interrupt is raised and cleared by register writes, so one hart can interrupt another.

A 32-bit register bus gives access to all state. Every 64-bit register appears as two 32-bit words, so 32-bit software can read and write them in halves. The counter moves forward only on cycles where the timebase tick enable is high. This lets the timebase run slower than the bus clock without a second clock domain.

Top module: `hart_timer_unit`

## Requirements
- R1: Out of reset the counter is 0, every compare register reads 0xFFFFFFFF in both halves, every software flag is 0, all interrupt outputs are low, `bus_ack` is low and `bus_rdata` is 0.
- R2: The counter increases by exactly one on each clock edge where `tick_en` is high and no counter write occurs. It holds its value when `tick_en` is low.
- R3: The counter is a single 64-bit quantity. The tick that takes the low word from 0xFFFFFFFF to 0 also increments the high word, on the same clock edge.
- R4: The counter low word is at byte offset 0xBFF8 and the high word at 0xBFFC. A write replaces only the addressed half. On a cycle with a write to either half, the counter does not increment, even when `tick_en` is high.
- R5: The compare register of hart n has its low word at 0x4000 + 8·n and its high word at 0x4000 + 8·n + 4. Each word can be written and read back independently.
- R6: `timer_irq[n]` is high exactly when the counter is greater than or equal to hart n's compare value, using unsigned 64-bit comparison. It follows the registers with no added delay, so it changes in the cycle after the register update that causes the change.
- R7: The software flag of hart n is at byte offset 4·n. A write stores bit 0 of the write data and ignores bits 31:1. `soft_irq[n]` equals the stored bit. A read returns the bit in position 0, with bits 31:1 zero.
- R8: A read of any other offset returns 0, and a write to it changes no state. This includes the slots of harts numbered NUM_HARTS and above. Address bits 1:0 are ignored.
- R9: `bus_ack` is high in the cycle after each cycle with `bus_sel` high, and low otherwise. For a read, `bus_rdata` in the `bus_ack` cycle holds the register value as it stood before the request edge. In every other cycle `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timebase tick; counter advances when high |
| bus_sel | input | 1 | Bus request in this cycle |
| bus_we | input | 1 | Request is a write when high, read when low |
| bus_addr | input | 16 | Byte offset within the unit |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| bus_ack | output | 1 | Response, one cycle after the request |
| timer_irq | output | NUM_HARTS | Per-hart timer interrupt level |
| soft_irq | output | NUM_HARTS | Per-hart software interrupt |

## Verification
The bench builds the unit with NUM_HARTS set to 3. With a count that is not a power of two, the slots for a fourth hart still fall on real address encodings. This lets the bench show that those slots read as zero and ignore writes, both in the software-flag region and in the compare region. Three harts also give enough separate compare values to show that a write to one hart's compare register leaves the other harts' interrupt levels unchanged. A counter preset near the low-word wrap brings the carry into the high word, and the write-over-tick priority, within a few cycles.

// File: rtl/htu_pkg.sv
package htu_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] SIP_BASE  = 16'h0000;
    localparam logic [ADDR_W-1:0] CMP_BASE  = 16'h4000;
    localparam logic [ADDR_W-1:0] CNT_LO_OF = 16'hBFF8;
    localparam logic [ADDR_W-1:0] CNT_HI_OF = 16'hBFFC;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_SIP,
        RG_CMP_LO,
        RG_CMP_HI,
        RG_CNT_LO,
        RG_CNT_HI
    } htu_region_e;
endpackage

// File: rtl/htu_decode.sv
module htu_decode
    import htu_pkg::*;
#(
    parameter int NUM_HARTS = 2,
    localparam int IDX_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output htu_region_e       region,
    output logic [IDX_W-1:0]  hart_idx
);
    localparam logic [ADDR_W-1:0] CMP_END = CMP_BASE + ADDR_W'(8 * NUM_HARTS);
    localparam logic [ADDR_W-1:0] SIP_END = SIP_BASE + ADDR_W'(4 * NUM_HARTS);

    logic [ADDR_W-1:0] word_a;
    logic [ADDR_W-1:0] cmp_off;
    logic              unused_lsb;

    assign word_a     = {addr[ADDR_W-1:2], 2'b00};
    assign cmp_off    = word_a - CMP_BASE;
    assign unused_lsb = ^addr[1:0];

    always_comb begin
        region   = RG_NONE;
        hart_idx = '0;
        if (word_a == CNT_LO_OF) begin
            region = RG_CNT_LO;
        end else if (word_a == CNT_HI_OF) begin
            region = RG_CNT_HI;
        end else if (word_a >= CMP_BASE && word_a < CMP_END) begin
            region   = cmp_off[2] ? RG_CMP_HI : RG_CMP_LO;
            hart_idx = cmp_off[3 +: IDX_W];
        end else if (word_a < SIP_END) begin
            region   = RG_SIP;
            hart_idx = word_a[2 +: IDX_W];
        end
    end
endmodule

// File: rtl/htu_counter.sv
module htu_counter
    import htu_pkg::*;
#(
    parameter int CNT_W = 64,
    localparam int HALF_W = CNT_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [HALF_W-1:0] wdata,
    output logic [CNT_W-1:0]  count
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_state_t;

    cnt_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_lo) begin
            state_d.count[HALF_W-1:0] = wdata;
        end else if (wr_hi) begin
            state_d.count[CNT_W-1:HALF_W] = wdata;
        end else if (tick_en) begin
            state_d.count = state_q.count + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign count = state_q.count;
endmodule

// File: rtl/htu_hart_slot.sv
module htu_hart_slot
    import htu_pkg::*;
#(
    parameter int CNT_W = 64,
    localparam int HALF_W = CNT_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cmp_lo,
    input  logic              wr_cmp_hi,
    input  logic              wr_sip,
    input  logic [HALF_W-1:0] wdata,
    input  logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  cmp,
    output logic              sip,
    output logic              timer_irq
);
    typedef struct packed {
        logic [CNT_W-1:0] cmp;
        logic             sip;
    } slot_state_t;

    slot_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_cmp_lo) state_d.cmp[HALF_W-1:0]     = wdata;
        if (wr_cmp_hi) state_d.cmp[CNT_W-1:HALF_W] = wdata;
        if (wr_sip)    state_d.sip                 = wdata[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.cmp <= '1;
            state_q.sip <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cmp       = state_q.cmp;
    assign sip       = state_q.sip;
    assign timer_irq = (count >= state_q.cmp);
endmodule

// File: rtl/hart_timer_unit.sv
module hart_timer_unit
    import htu_pkg::*;
#(
    parameter int NUM_HARTS = 2,
    localparam int IDX_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_en,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 bus_ack,
    output logic [NUM_HARTS-1:0] timer_irq,
    output logic [NUM_HARTS-1:0] soft_irq
);
    typedef struct packed {
        logic              ack;
        logic [DATA_W-1:0] rdata;
    } resp_state_t;

    resp_state_t       resp_d, resp_q;
    htu_region_e       region;
    logic [IDX_W-1:0]  hart_idx;
    logic              wr_any;
    logic [CNT_W-1:0]  cnt_val;
    logic [CNT_W-1:0]  cmp_val [NUM_HARTS];
    logic [DATA_W-1:0] rd_val;

    assign wr_any = bus_sel && bus_we;

    htu_decode #(.NUM_HARTS(NUM_HARTS)) u_decode (
        .addr     (bus_addr),
        .region   (region),
        .hart_idx (hart_idx)
    );

    htu_counter #(.CNT_W(CNT_W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .wr_lo   (wr_any && region == RG_CNT_LO),
        .wr_hi   (wr_any && region == RG_CNT_HI),
        .wdata   (bus_wdata),
        .count   (cnt_val)
    );

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_slot
        logic hit;
        assign hit = wr_any && (hart_idx == IDX_W'(h));
        htu_hart_slot #(.CNT_W(CNT_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_cmp_lo (hit && region == RG_CMP_LO),
            .wr_cmp_hi (hit && region == RG_CMP_HI),
            .wr_sip    (hit && region == RG_SIP),
            .wdata     (bus_wdata),
            .count     (cnt_val),
            .cmp       (cmp_val[h]),
            .sip       (soft_irq[h]),
            .timer_irq (timer_irq[h])
        );
    end

    always_comb begin
        rd_val = '0;
        case (region)
            RG_CNT_LO: rd_val = cnt_val[DATA_W-1:0];
            RG_CNT_HI: rd_val = cnt_val[CNT_W-1:DATA_W];
            RG_CMP_LO: rd_val = cmp_val[hart_idx][DATA_W-1:0];
            RG_CMP_HI: rd_val = cmp_val[hart_idx][CNT_W-1:DATA_W];
            RG_SIP:    rd_val = {{(DATA_W-1){1'b0}}, soft_irq[hart_idx]};
            default:   rd_val = '0;
        endcase
    end

    always_comb begin
        resp_d.ack   = bus_sel;
        resp_d.rdata = (bus_sel && !bus_we) ? rd_val : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) resp_q <= '0;
        else        resp_q <= resp_d;
    end

    assign bus_ack   = resp_q.ack;
    assign bus_rdata = resp_q.rdata;
endmodule

// File: rtl/htu_checker.sv
module htu_checker #(
    parameter int NUM_HARTS = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick_en,
    input logic                 sel,
    input logic                 we,
    input logic [13:0]          addr_w,
    input logic [31:0]          wdata,
    input logic                 ack,
    input logic [31:0]          rdata,
    input logic [63:0]          count,
    input logic [NUM_HARTS-1:0] timer_irq,
    input logic [NUM_HARTS-1:0] soft_irq
);
    logic cnt_wr;
    assign cnt_wr = sel && we && (addr_w == 14'h2FFE || addr_w == 14'h2FFF);

    a_r2_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !cnt_wr) |=> (count == $past(count) + 64'd1));

    a_r2_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !cnt_wr) |=> $stable(count));

    a_r4_write_wins_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && we && addr_w == 14'h2FFE) |=>
            (count[31:0] == $past(wdata) && count[63:32] == $past(count[63:32])));

    a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && we) |=> ((timer_irq & $past(timer_irq)) == $past(timer_irq)));

    a_r7_soft_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && we) |=> $stable(soft_irq));

    a_r9_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
        sel |=> ack);

    a_r9_no_spurious_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !ack);

    a_r9_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |-> (rdata == 32'd0));
endmodule

bind hart_timer_unit htu_checker #(.NUM_HARTS(NUM_HARTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .sel       (bus_sel),
    .we        (bus_we),
    .addr_w    (bus_addr[15:2]),
    .wdata     (bus_wdata),
    .ack       (bus_ack),
    .rdata     (bus_rdata),
    .count     (cnt_val),
    .timer_irq (timer_irq),
    .soft_irq  (soft_irq)
);

// File: tb/sim_hart_timer_unit.sv
module sim_hart_timer_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NH = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic [15:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_ack;
    logic [NH-1:0] timer_irq;
    logic [NH-1:0] soft_irq;

    int checks = 0;
    int errors = 0;

    logic [63:0]   m_cnt;
    logic [63:0]   m_cmp [NH];
    logic [NH-1:0] m_sip;

    always #(CLK_PERIOD/2) clk = ~clk;

    hart_timer_unit #(.NUM_HARTS(NH)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .timer_irq(timer_irq), .soft_irq(soft_irq)
    );

    task automatic check(input logic ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string rtag(input logic [15:0] a);
        logic [15:0] w;
        w = {a[15:2], 2'b00};
        if (w == 16'hBFF8 || w == 16'hBFFC) return "R4";
        if (w >= 16'h4000 && w < 16'h4000 + 16'(8*NH)) return "R5";
        if (w < 16'(4*NH)) return "R7";
        return "R8";
    endfunction

    function automatic logic [31:0] m_read(input logic [15:0] a);
        logic [15:0] w;
        int idx;
        w = {a[15:2], 2'b00};
        if (w == 16'hBFF8) return m_cnt[31:0];
        if (w == 16'hBFFC) return m_cnt[63:32];
        if (w >= 16'h4000 && w < 16'h4000 + 16'(8*NH)) begin
            idx = int'((w - 16'h4000) >> 3);
            return w[2] ? m_cmp[idx][63:32] : m_cmp[idx][31:0];
        end
        if (w < 16'(4*NH)) return {31'd0, m_sip[int'(w >> 2)]};
        return 32'd0;
    endfunction

    // returns 1 when the write hits the counter
    function automatic logic m_write(input logic [15:0] a, input logic [31:0] d);
        logic [15:0] w;
        int idx;
        w = {a[15:2], 2'b00};
        if (w == 16'hBFF8) begin m_cnt[31:0] = d; return 1'b1; end
        if (w == 16'hBFFC) begin m_cnt[63:32] = d; return 1'b1; end
        if (w >= 16'h4000 && w < 16'h4000 + 16'(8*NH)) begin
            idx = int'((w - 16'h4000) >> 3);
            if (w[2]) m_cmp[idx][63:32] = d;
            else      m_cmp[idx][31:0]  = d;
        end else if (w < 16'(4*NH)) begin
            m_sip[int'(w >> 2)] = d[0];
        end
        return 1'b0;
    endfunction

    function automatic logic [NH-1:0] m_tirq();
        logic [NH-1:0] v;
        for (int i = 0; i < NH; i++) v[i] = (m_cnt >= m_cmp[i]);
        return v;
    endfunction

    // one bus cycle, entered and left at a falling edge
    task automatic cyc(input logic s, input logic w, input logic [15:0] a,
                       input logic [31:0] d, input logic t);
        logic [31:0] exp_rd;
        logic        cw;
        bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d; tick_en = t;
        exp_rd = (s && !w) ? m_read(a) : 32'd0;
        cw = 1'b0;
        if (s && w) cw = m_write(a, d);
        if (t && !cw) m_cnt = m_cnt + 64'd1;   // R2, R3, R4 write wins
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; tick_en = 1'b0;
        check(bus_ack == s, "R9", "ack", 64'(bus_ack), 64'(s));
        check(bus_rdata == exp_rd, (s && !w) ? rtag(a) : "R9", "rdata",
              64'(bus_rdata), 64'(exp_rd));
        check(timer_irq == m_tirq(), "R6", "timer_irq",
              64'(timer_irq), 64'(m_tirq()));
        check(soft_irq == m_sip, "R7", "soft_irq", 64'(soft_irq), 64'(m_sip));
    endtask

    task automatic rd_expect(input logic [15:0] a, input logic [31:0] exp,
                             input string req);
        cyc(1'b1, 1'b0, a, 32'd0, 1'b0);
        check(bus_rdata == exp, req, "directed read", 64'(bus_rdata), 64'(exp));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_cnt = '0;
        m_sip = '0;
        for (int i = 0; i < NH; i++) m_cmp[i] = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(bus_ack == 1'b0, "R1", "ack", 64'(bus_ack), 64'd0);
        check(bus_rdata == 32'd0, "R1", "rdata", 64'(bus_rdata), 64'd0);
        check(timer_irq == '0, "R1", "timer_irq", 64'(timer_irq), 64'd0);
        check(soft_irq == '0, "R1", "soft_irq", 64'(soft_irq), 64'd0);
        rd_expect(16'h4008, 32'hFFFF_FFFF, "R1");
        rd_expect(16'h400C, 32'hFFFF_FFFF, "R1");
        rd_expect(16'hBFF8, 32'd0, "R1");

        // R2: ticks only when enabled
        cyc(1'b0, 1'b0, 16'h0, 32'd0, 1'b1);
        cyc(1'b0, 1'b0, 16'h0, 32'd0, 1'b0);
        cyc(1'b0, 1'b0, 16'h0, 32'd0, 1'b1);
        rd_expect(16'hBFF8, 32'd2, "R2");

        // R3: carry into high word
        cyc(1'b1, 1'b1, 16'hBFFC, 32'd5, 1'b0);
        cyc(1'b1, 1'b1, 16'hBFF8, 32'hFFFF_FFFE, 1'b0);
        cyc(1'b0, 1'b0, 16'h0, 32'd0, 1'b1);
        rd_expect(16'hBFFC, 32'd5, "R3");
        cyc(1'b0, 1'b0, 16'h0, 32'd0, 1'b1);
        rd_expect(16'hBFFC, 32'd6, "R3");
        rd_expect(16'hBFF8, 32'd0, "R3");

        // R4: write beats tick, other half kept
        cyc(1'b1, 1'b1, 16'hBFF8, 32'd100, 1'b1);
        rd_expect(16'hBFF8, 32'd100, "R4");
        rd_expect(16'hBFFC, 32'd6, "R4");
        cyc(1'b1, 1'b1, 16'hBFFC, 32'd0, 1'b1);
        rd_expect(16'hBFF8, 32'd100, "R4");

        // R5, R6: compare of hart 1 just above counter
        cyc(1'b1, 1'b1, 16'h400C, 32'd0, 1'b0);
        cyc(1'b1, 1'b1, 16'h4008, 32'd102, 1'b0);
        rd_expect(16'h4008, 32'd102, "R5");
        check(timer_irq[1] == 1'b0, "R6", "below compare", 64'(timer_irq), 64'd0);
        cyc(1'b0, 1'b0, 16'h0, 32'd0, 1'b1);
        cyc(1'b0, 1'b0, 16'h0, 32'd0, 1'b1);
        check(timer_irq == 3'b010, "R6", "at compare", 64'(timer_irq), 64'd2);
        cyc(1'b1, 1'b1, 16'h400C, 32'd1, 1'b0);
        check(timer_irq == 3'b000, "R6", "compare raised", 64'(timer_irq), 64'd0);

        // R7: bit 0 only
        cyc(1'b1, 1'b1, 16'h0008, 32'hFFFF_FFFE, 1'b0);
        check(soft_irq == 3'b000, "R7", "upper bits ignored", 64'(soft_irq), 64'd0);
        cyc(1'b1, 1'b1, 16'h0008, 32'h0000_0003, 1'b0);
        check(soft_irq == 3'b100, "R7", "set", 64'(soft_irq), 64'd4);
        rd_expect(16'h0008, 32'd1, "R7");
        cyc(1'b1, 1'b1, 16'h0008, 32'd0, 1'b0);
        check(soft_irq == 3'b000, "R7", "clear", 64'(soft_irq), 64'd0);

        // R8: unmapped and beyond-count slots
        cyc(1'b1, 1'b1, 16'h000C, 32'd1, 1'b0);
        check(soft_irq == 3'b000, "R8", "hart3 sip write", 64'(soft_irq), 64'd0);
        rd_expect(16'h000C, 32'd0, "R8");
        cyc(1'b1, 1'b1, 16'h4018, 32'd0, 1'b0);
        cyc(1'b1, 1'b1, 16'h401C, 32'd0, 1'b0);
        rd_expect(16'h4018, 32'd0, "R8");
        rd_expect(16'h0100, 32'd0, "R8");
        cyc(1'b1, 1'b1, 16'h8000, 32'hDEAD_BEEF, 1'b0);
        rd_expect(16'h8000, 32'd0, "R8");
        rd_expect(16'hBFFB, m_cnt[31:0], "R8");

        // constrained random mix
        for (int n = 0; n < 4000; n++) begin
            logic [15:0] a;
            logic [31:0] d;
            logic [15:0] pool [12];
            pool = '{16'h0000, 16'h0004, 16'h0008, 16'h000C, 16'h4000, 16'h4004,
                     16'h4010, 16'h4014, 16'h4018, 16'hBFF8, 16'hBFFC, 16'h2000};
            a = pool[$urandom_range(0, 11)] | 16'($urandom_range(0, 3) == 0 ? $urandom_range(0, 3) : 0);
            if (a[2] && a != 16'h0004 && a != 16'h000C) d = ($urandom_range(0, 7) == 0) ? 32'd1 : 32'd0;
            else if ($urandom_range(0, 9) == 0) d = $urandom;
            else d = m_cnt[31:0] + 32'($urandom_range(0, 40)) - 32'd20;
            cyc($urandom_range(0, 9) < 7, $urandom_range(0, 1) == 1, a, d,
                $urandom_range(0, 1) == 1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule